// File: doc/BRIEF.md
# Dual-Channel Limit Alert Monitor

This block watches 12-bit conversion results that arrive one at a time from either of two input channels. Each channel has its own upper limit, lower limit and hysteresis margin. A result above the upper limit, or below the lower limit, latches an alert for that limit. The alert is released only when a later result on the same channel comes back inside the violated limit by at least the hysteresis margin. A clear command releases every alert at once.

Every accepted result is also packed into a 16-bit readback word. The word holds the data, the channel it came from and a flag that shows whether any channel has an alert active. A small register port reaches the six limit and hysteresis registers and a command register. The alert pin is the OR of the four latched status bits.

Top module: `limit_alert_monitor`

## Requirements
- R1: After reset, every upper limit reads 0x0FFF, every lower limit reads 0x0000 and every hysteresis register reads 0x0008. `status_o`, `alert_o` and `result_word_o` are all zero.
- R2: Register addresses are: 0 command, 1 ch1 upper, 2 ch1 lower, 3 ch1 hysteresis, 4 ch2 upper, 5 ch2 lower, 6 ch2 hysteresis. Writes store only bits 11:0, and bits 15:12 read back as zero. Address 0 reads zero. A write to address 7 changes no register, and address 7 reads zero.
- R3: A result strictly greater than its channel's upper limit sets that channel's high status bit. A result equal to the limit does not set it.
- R4: A latched high bit clears only on a later result on that channel at or below (upper − N). If N exceeds the upper limit, the release threshold is 0.
- R5: A result strictly less than its channel's lower limit sets that channel's low status bit. A result equal to the limit does not set it.
- R6: A latched low bit clears only on a later result on that channel at or above (lower + N). If that sum exceeds 0xFFF, the release threshold is 0xFFF.
- R7: `status_o` bit order is [0] ch1 high, [1] ch1 low, [2] ch2 high, [3] ch2 low. A result updates only the bits of its own channel (`res_chan_i` 0 = ch1, 1 = ch2).
- R8: `result_word_o` is loaded on each valid result. Bit 15 is the alert flag, bits 14:13 are zero, bit 12 is the channel identifier, and bits 11:0 are the data.
- R9: The alert flag in the word is set when any status bit of any channel is active after the result is evaluated, including bits of the other channel.
- R10: A write to address 0 with both bit 2 and bit 1 set clears all status bits and `alert_o`. A write with only one of those bits set has no effect.
- R11: `alert_o` equals the OR of the status bits. It is registered, and it changes on the clock edge that samples the result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_chan_i | input | 1 | Channel of the result (0 = ch1) |
| res_data_i | input | 12 | Conversion result, straight binary |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on the address) |
| alert_o | output | 1 | Alert pin level |
| result_word_o | output | 16 | Packed result word |
| status_o | output | 4 | Latched limit violations |

## Verification
Status, the alert pin and the result word are all registered on the edge that samples the strobe or the command write. Each is therefore due one edge after the inputs are driven. The bench drives on a falling edge and samples on the next falling edge, half a cycle after that due edge. Register reads are combinational, so the bench samples them a short delay after it sets the address, with no edge in between.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam int DW  = 12;  // result / limit width
  localparam int WW  = 16;  // register and word width
  localparam int NCH = 2;   // channels
  localparam int RPC = 3;   // registers per channel: upper, lower, hysteresis

  localparam logic [DW-1:0] HI_RST = '1;
  localparam logic [DW-1:0] LO_RST = '0;
  localparam logic [DW-1:0] HY_RST = DW'(8);

  typedef enum logic [1:0] {
    K_UPPER = 2'd0,
    K_LOWER = 2'd1,
    K_HYST  = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/lam_regs.sv
module lam_regs
  import lam_pkg::*;
#(
  parameter int NC = NCH,
  parameter int AW = $clog2(RPC*NC+1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [WW-1:0]          wdata_i,
  output logic [WW-1:0]          rdata_o,
  output logic                   clr_o,
  output logic [NC-1:0][DW-1:0]  hi_o,
  output logic [NC-1:0][DW-1:0]  lo_o,
  output logic [NC-1:0][DW-1:0]  hy_o
);
  localparam int NREG = RPC*NC + 1;
  localparam int PAD  = WW - DW;

  // command: both bit 2 and bit 1 required
  assign clr_o = we_i && (addr_i == '0) && wdata_i[2] && wdata_i[1];

  for (genvar c = 0; c < NC; c++) begin : g_ch
    localparam logic [AW-1:0] A_HI = AW'(1 + RPC*c + int'(K_UPPER));
    localparam logic [AW-1:0] A_LO = AW'(1 + RPC*c + int'(K_LOWER));
    localparam logic [AW-1:0] A_HY = AW'(1 + RPC*c + int'(K_HYST));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_o[c] <= HI_RST;
        lo_o[c] <= LO_RST;
        hy_o[c] <= HY_RST;
      end else if (we_i) begin
        if (addr_i == A_HI) hi_o[c] <= wdata_i[DW-1:0];
        if (addr_i == A_LO) lo_o[c] <= wdata_i[DW-1:0];
        if (addr_i == A_HY) hy_o[c] <= wdata_i[DW-1:0];
      end
    end

    assert_upper_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_HI) |=> hi_o[c] == $past(wdata_i[DW-1:0]));
    assert_hyst_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_HY) |=> hy_o[c] == $past(wdata_i[DW-1:0]));
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NC; c++) begin
      if (addr_i == AW'(1 + RPC*c + int'(K_UPPER))) rdata_o = {{PAD{1'b0}}, hi_o[c]};
      if (addr_i == AW'(1 + RPC*c + int'(K_LOWER))) rdata_o = {{PAD{1'b0}}, lo_o[c]};
      if (addr_i == AW'(1 + RPC*c + int'(K_HYST)))  rdata_o = {{PAD{1'b0}}, hy_o[c]};
    end
  end

  if (NREG < (1 << AW)) begin : g_unused
    assert_unused_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i >= AW'(NREG)) |=> ($stable(hi_o) && $stable(lo_o) && $stable(hy_o)));
  end
endmodule

// File: rtl/lam_window.sv
module lam_window
  import lam_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hy_i,
  output logic          hi_nx_o,
  output logic          lo_nx_o,
  output logic          hi_st_o,
  output logic          lo_st_o
);
  logic [DW-1:0] rel_hi, rel_lo;
  logic [DW:0]   lo_sum;

  // saturating release thresholds
  assign rel_hi = (hi_i >= hy_i) ? (hi_i - hy_i) : '0;
  assign lo_sum = {1'b0, lo_i} + {1'b0, hy_i};
  assign rel_lo = lo_sum[DW] ? '1 : lo_sum[DW-1:0];

  always_comb begin
    hi_nx_o = hi_st_o;
    lo_nx_o = lo_st_o;
    if (clr_i) begin
      hi_nx_o = 1'b0;
      lo_nx_o = 1'b0;
    end else if (upd_i) begin
      if (hi_st_o) hi_nx_o = !(data_i <= rel_hi);
      else         hi_nx_o = data_i > hi_i;
      if (lo_st_o) lo_nx_o = !(data_i >= rel_lo);
      else         lo_nx_o = data_i < lo_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_st_o <= 1'b0;
      lo_st_o <= 1'b0;
    end else begin
      hi_st_o <= hi_nx_o;
      lo_st_o <= lo_nx_o;
    end
  end

  assert_hi_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_st_o) |-> $past(upd_i && data_i > hi_i));
  assert_hi_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_st_o) |-> $past(clr_i || (upd_i &&
      (({1'b0, data_i} + {1'b0, hy_i} <= {1'b0, hi_i}) || data_i == '0))));
  assert_lo_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_st_o) |-> $past(upd_i && data_i < lo_i));
  assert_lo_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lo_st_o) |-> $past(clr_i || (upd_i &&
      (({1'b0, data_i} >= {1'b0, lo_i} + {1'b0, hy_i}) || data_i == '1))));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> ($stable(hi_st_o) && $stable(lo_st_o)));
endmodule

// File: rtl/lam_pack.sv
module lam_pack
  import lam_pkg::*;
#(
  parameter int CW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [CW-1:0] chan_i,
  input  logic [DW-1:0] data_i,
  input  logic          flag_i,
  output logic [WW-1:0] word_o
);
  localparam int ZW = WW - 1 - CW - DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (valid_i) word_o <= {flag_i, {ZW{1'b0}}, chan_i, data_i};
  end

  assert_word_layout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (word_o[DW +: CW] == $past(chan_i)) && (word_o[DW-1:0] == $past(data_i))
                && (word_o[WW-2 -: ZW] == '0));
endmodule

// File: rtl/limit_alert_monitor.sv
module limit_alert_monitor
  import lam_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic          res_chan_i,
  input  logic [11:0]   res_data_i,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  output logic          alert_o,
  output logic [15:0]   result_word_o,
  output logic [3:0]    status_o
);
  localparam int CW = $clog2(NCH);
  localparam int AW = $clog2(RPC*NCH+1);

  logic                   clr;
  logic [NCH-1:0][DW-1:0] hi, lo, hy;
  logic [2*NCH-1:0]       st_nx;

  lam_regs #(.NC(NCH), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .clr_o   (clr),
    .hi_o    (hi),
    .lo_o    (lo),
    .hy_o    (hy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_win
    lam_window u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (res_valid_i && (res_chan_i == CW'(c))),
      .clr_i   (clr),
      .data_i  (res_data_i),
      .hi_i    (hi[c]),
      .lo_i    (lo[c]),
      .hy_i    (hy[c]),
      .hi_nx_o (st_nx[2*c]),
      .lo_nx_o (st_nx[2*c+1]),
      .hi_st_o (status_o[2*c]),
      .lo_st_o (status_o[2*c+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_o <= 1'b0;
    else         alert_o <= |st_nx;
  end

  lam_pack #(.CW(CW)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (res_valid_i),
    .chan_i  (res_chan_i),
    .data_i  (res_data_i),
    .flag_i  (|st_nx),
    .word_o  (result_word_o)
  );

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!alert_o && status_o == '0));
  assert_alert_or_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o == (|status_o));
  assert_flag_any_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> result_word_o[WW-1] == (|status_o));
endmodule

// File: tb/limit_alert_monitor_test.sv
module limit_alert_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_chan = 1'b0;
  logic [11:0] res_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        alert;
  logic [15:0] word;
  logic [3:0]  status;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  limit_alert_monitor uut (
    .clk_i(clk), .rst_ni(rst_n),
    .res_valid_i(res_valid), .res_chan_i(res_chan), .res_data_i(res_data),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .alert_o(alert), .result_word_o(word), .status_o(status)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic ch, input logic [11:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 status", {12'h0, status}, 16'h0);
    check("R1 alert", {15'h0, alert}, 16'h0);
    check("R1 word", word, 16'h0);
    for (int c = 0; c < 2; c++) begin
      rd(3'(1 + 3*c), v); check("R1 upper", v, 16'h0FFF);
      rd(3'(2 + 3*c), v); check("R1 lower", v, 16'h0000);
      rd(3'(3 + 3*c), v); check("R1 hyst", v, 16'h0008);
    end
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(3'd1, 16'hABCD);
    rd(3'd1, v); check("R2 upper bits zero", v, 16'h0BCD);
    wr(3'd7, 16'h1234);
    rd(3'd1, v); check("R2 unused write", v, 16'h0BCD);
    for (int a = 2; a < 7; a++) begin
      rd(3'(a), v);
      check("R2 unused write", v, (a == 3 || a == 6) ? 16'h0008 : ((a == 4) ? 16'h0FFF : 16'h0000));
    end
    rd(3'd0, v); check("R2 cmd reads zero", v, 16'h0);
    rd(3'd7, v); check("R2 addr7 reads zero", v, 16'h0);
  endtask

  task automatic t_upper;
    wr(3'd1, 16'h0800);
    wr(3'd3, 16'h0010);
    send(1'b0, 12'h800);
    check("R3 equal no alert", {12'h0, status}, 16'h0);
    send(1'b0, 12'h801);
    check("R3 above sets", {12'h0, status}, 16'h1);
    check("R11 alert rises", {15'h0, alert}, 16'h1);
    send(1'b0, 12'h7F1);
    check("R4 hold inside margin", {12'h0, status}, 16'h1);
    send(1'b0, 12'h7F0);
    check("R4 release", {12'h0, status}, 16'h0);
    check("R11 alert falls", {15'h0, alert}, 16'h0);
  endtask

  task automatic t_lower;
    wr(3'd2, 16'h0100);
    send(1'b0, 12'h100);
    check("R5 equal no alert", {12'h0, status}, 16'h0);
    send(1'b0, 12'h0FF);
    check("R5 below sets", {12'h0, status}, 16'h2);
    send(1'b0, 12'h10F);
    check("R6 hold inside margin", {12'h0, status}, 16'h2);
    send(1'b0, 12'h110);
    check("R6 release", {12'h0, status}, 16'h0);
  endtask

  task automatic t_saturate;
    wr(3'd4, 16'h0004);
    send(1'b1, 12'h005);
    check("R4 ch2 high sets bit2", {12'h0, status}, 16'h4);
    send(1'b1, 12'h001);
    check("R4 saturated hold", {12'h0, status}, 16'h4);
    send(1'b1, 12'h000);
    check("R4 saturated release", {12'h0, status}, 16'h0);
    wr(3'd4, 16'h0FFF);
    wr(3'd5, 16'h0FFA);
    send(1'b1, 12'hFF9);
    check("R6 ch2 low sets bit3", {12'h0, status}, 16'h8);
    send(1'b1, 12'hFFE);
    check("R6 saturated hold", {12'h0, status}, 16'h8);
    send(1'b1, 12'hFFF);
    check("R6 saturated release", {12'h0, status}, 16'h0);
  endtask

  task automatic t_flag;
    wr(3'd5, 16'h0000);
    send(1'b0, 12'h801);
    check("R9 own flag", word, 16'h8801);
    send(1'b1, 12'h123);
    check("R7 other channel untouched", {12'h0, status}, 16'h1);
    check("R9 other channel flag", word, 16'h9123);
    send(1'b0, 12'h7F0);
    check("R8 clean word", word, 16'h07F0);
  endtask

  task automatic t_clear;
    send(1'b0, 12'h0FF);
    check("R10 setup", {12'h0, status}, 16'h2);
    wr(3'd0, 16'h0002);
    check("R10 bit1 alone", {11'h0, alert, status}, 16'h12);
    wr(3'd0, 16'h0004);
    check("R10 bit2 alone", {11'h0, alert, status}, 16'h12);
    wr(3'd0, 16'h0006);
    check("R10 cleared", {11'h0, alert, status}, 16'h00);
    send(1'b1, 12'hABC);
    check("R8 ch2 word", word, 16'h1ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_upper();
    t_lower();
    t_saturate();
    t_flag();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule